// File: doc/BRIEF.md
# Two-Float Pump Hysteresis Controller

This block runs one pump from two float switches mounted at different heights in a small vessel. The pump starts once the liquid reaches the upper float. It keeps running while the lower float remains wetted, and it stops only after both floats read dry. Between the two floats the next pump state depends on the present one, and that dependence is the hysteresis band. It holds a fill cycle or a drain cycle until the band is left at one edge.

Each float input is asynchronous and may bounce. It passes through a multi-stage synchronizer and then a stability filter before the decision logic sees it. A sticky fault flag reports the upper float wet while the lower float reads dry. Physically this can only occur if the lower float has failed, so the pump is forced on in that case. The decision register can be built in either of two equivalent forms, chosen by a parameter.

Top module: `pump_hyst_ctrl`

## Requirements
- R1: Switch inputs `low_sw` and `high_sw` use 1 = float wetted (active) and 0 = dry. Output `pump_on` uses 1 = pump running and 0 = pump stopped.
- R2: When both filtered switches read 0, the pump is stopped on the next clock.
- R3: Whenever the filtered upper switch reads 1, the pump runs on the next clock, whatever the lower switch reads.
- R4: With the filtered lower switch at 1 and the upper switch at 0, the pump keeps its present state.
- R5: A switch level is accepted only after the synchronized input has differed from the accepted level for STABLE_CYCLES consecutive samples. A pulse shorter than that has no effect on `pump_on` or `sensor_fault`.
- R6: A held input change at a port reaches `pump_on` exactly SYNC_STAGES + STABLE_CYCLES + 1 clock edges later.
- R7: `sensor_fault` goes to 1 one clock after the filtered inputs show upper=1 with lower=0. It then stays at 1 until reset.
- R8: Synchronous active-high `rst` stops the pump, clears `sensor_fault` and returns both filters to the dry level.
- R9: The parameter STATE_FORM selects either a sum-of-products register or a set/reset register. Both give identical `pump_on` and `sensor_fault` for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_sw | input | 1 | Lower float switch, asynchronous, 1 = wetted |
| high_sw | input | 1 | Upper float switch, asynchronous, 1 = wetted |
| pump_on | output | 1 | Registered pump command, 1 = run |
| sensor_fault | output | 1 | Sticky implausible-switch flag |

## Verification
The bench builds two instances with STABLE_CYCLES = 4 and the default two synchronizer stages, one for each STATE_FORM. With these values the full filter latency is only seven edges, so every ordered pair of the four switch combinations can be swept from both pump states in a short run. The short window also allows exact latency checks, and pulses one cycle below the acceptance threshold can be placed precisely. Comparing the two instances on every cycle covers the equivalence of the two register forms.

// File: rtl/pump_ctl_pkg.sv
package pump_ctl_pkg;
   // Implementation choice for the pump decision register
   typedef enum logic {
      FORM_SUM_OF_PRODUCTS = 1'b0,
      FORM_SET_RESET       = 1'b1
   } state_form_e;

   localparam int unsigned NUM_SWITCHES = 2;
   localparam int unsigned IDX_LOW      = 0;
   localparam int unsigned IDX_HIGH     = 1;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lvl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/lvl_debounce.sv
module lvl_debounce #(
   parameter int unsigned STABLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STABLE_CYCLES < 2) begin : g_bad_window
      $error("lvl_debounce: STABLE_CYCLES must be at least 2");
   end

   localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout    <= 1'b0;
         run_cnt <= '0;
      end else if (din == dout) begin
         run_cnt <= '0;
      end else if (run_cnt == LAST) begin
         dout    <= din;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pump_state_reg.sv
module pump_state_reg
   import pump_ctl_pkg::*;
#(
   parameter state_form_e STATE_FORM = FORM_SUM_OF_PRODUCTS
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl_low,
   input  logic lvl_high,
   output logic run_q
);
   logic run_d;

   if (STATE_FORM == FORM_SUM_OF_PRODUCTS) begin : g_sop
      always_comb run_d = lvl_high | (lvl_low & run_q);
   end else begin : g_sr
      logic set_req;
      logic clr_req;
      assign set_req = lvl_high;
      assign clr_req = ~(lvl_high | lvl_low);
      always_comb begin
         if (set_req)      run_d = 1'b1;
         else if (clr_req) run_d = 1'b0;
         else              run_d = run_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= run_d;
   end
endmodule

// File: rtl/pump_hyst_ctrl.sv
module pump_hyst_ctrl
   import pump_ctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned STABLE_CYCLES = 16,
   parameter state_form_e STATE_FORM    = FORM_SUM_OF_PRODUCTS
) (
   input  logic clk,
   input  logic rst,
   input  logic low_sw,
   input  logic high_sw,
   output logic pump_on,
   output logic sensor_fault
);
   logic [NUM_SWITCHES-1:0] raw_lvl;
   logic [NUM_SWITCHES-1:0] sync_lvl;
   logic [NUM_SWITCHES-1:0] deb_lvl;

   assign raw_lvl[IDX_LOW]  = low_sw;
   assign raw_lvl[IDX_HIGH] = high_sw;

   for (genvar i = 0; i < NUM_SWITCHES; i++) begin : g_sw
      lvl_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst (rst),
         .din (raw_lvl[i]),
         .dout(sync_lvl[i])
      );
      lvl_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_deb (
         .clk (clk),
         .rst (rst),
         .din (sync_lvl[i]),
         .dout(deb_lvl[i])
      );
   end

   pump_state_reg #(.STATE_FORM(STATE_FORM)) u_state (
      .clk     (clk),
      .rst     (rst),
      .lvl_low (deb_lvl[IDX_LOW]),
      .lvl_high(deb_lvl[IDX_HIGH]),
      .run_q   (pump_on)
   );

   // Sticky flag for upper float wet while lower reads dry
   always_ff @(posedge clk) begin
      if (rst)
         sensor_fault <= 1'b0;
      else if (deb_lvl[IDX_HIGH] && !deb_lvl[IDX_LOW])
         sensor_fault <= 1'b1;
   end
endmodule

// File: rtl/pump_hyst_ctrl_chk.sv
module pump_hyst_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic deb_low,
   input logic deb_high,
   input logic sync_low,
   input logic sync_high,
   input logic pump_on,
   input logic sensor_fault
);
   p_stop_dry_r2: assert property (@(posedge clk) disable iff (rst)
      (!deb_low && !deb_high) |=> !pump_on);

   p_start_high_r3: assert property (@(posedge clk) disable iff (rst)
      deb_high |=> pump_on);

   p_hold_band_r4: assert property (@(posedge clk) disable iff (rst)
      (deb_low && !deb_high) |=> $stable(pump_on));

   p_accept_low_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(deb_low) |-> (deb_low == $past(sync_low)));

   p_accept_high_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(deb_high) |-> (deb_high == $past(sync_high)));

   p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
      (deb_high && !deb_low) |=> sensor_fault);

   p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      sensor_fault |=> sensor_fault);

   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (!pump_on && !sensor_fault));
endmodule

bind pump_hyst_ctrl pump_hyst_ctrl_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .deb_low     (deb_lvl[0]),
   .deb_high    (deb_lvl[1]),
   .sync_low    (sync_lvl[0]),
   .sync_high   (sync_lvl[1]),
   .pump_on     (pump_on),
   .sensor_fault(sensor_fault)
);

// File: tb/pump_hyst_ctrl_test.sv
module pump_hyst_ctrl_test;
   import pump_ctl_pkg::*;

   localparam int unsigned SYNC_N = 2;
   localparam int unsigned DEB_N  = 4;
   localparam int unsigned LAT    = SYNC_N + DEB_N + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic low_sw = 1'b0;
   logic high_sw = 1'b0;
   logic pump_a, fault_a, pump_b, fault_b;

   int checks = 0;
   int errors = 0;
   logic m_pump = 1'b0;
   logic m_fault = 1'b0;

   always #10 clk = ~clk;

   pump_hyst_ctrl #(.SYNC_STAGES(SYNC_N), .STABLE_CYCLES(DEB_N),
                    .STATE_FORM(FORM_SUM_OF_PRODUCTS)) uut (
      .clk(clk), .rst(rst), .low_sw(low_sw), .high_sw(high_sw),
      .pump_on(pump_a), .sensor_fault(fault_a));

   pump_hyst_ctrl #(.SYNC_STAGES(SYNC_N), .STABLE_CYCLES(DEB_N),
                    .STATE_FORM(FORM_SET_RESET)) uut_sr (
      .clk(clk), .rst(rst), .low_sw(low_sw), .high_sw(high_sw),
      .pump_on(pump_b), .sensor_fault(fault_b));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // R9: compare the two register forms on every cycle
   always @(negedge clk) begin
      if (!rst && ((pump_a !== pump_b) || (fault_a !== fault_b))) begin
         errors++;
         $display("FAIL R9: actual pump/fault %b%b expected %b%b",
                  pump_b, fault_b, pump_a, fault_a);
      end
   end

   task automatic settle(input logic a, input logic b);
      low_sw  = a;
      high_sw = b;
      repeat (LAT + 3) @(negedge clk);
      m_pump  = b | (a & m_pump);
      if (b && !a) m_fault = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; low_sw = 1'b0; high_sw = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_pump = 1'b0; m_fault = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R8 reset pump", pump_a, 1'b0);
      check("R8 reset fault", fault_a, 1'b0);

      // R6 latency: both floats wetted, pump starts after LAT edges
      low_sw = 1'b1; high_sw = 1'b1;
      repeat (LAT - 1) @(negedge clk);
      check("R6 before latency", pump_a, 1'b0);
      @(negedge clk);
      check("R6 at latency", pump_a, 1'b1);
      repeat (3) @(negedge clk);
      // R6 latency for stop: both dry
      low_sw = 1'b0; high_sw = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      check("R6 stop before latency", pump_a, 1'b1);
      @(negedge clk);
      check("R6 stop at latency", pump_a, 1'b0);
      repeat (3) @(negedge clk);
      m_pump = 1'b0;

      // R5: short pulse on upper float ignored
      high_sw = 1'b1; low_sw = 1'b1;
      repeat (DEB_N - 1) @(negedge clk);
      high_sw = 1'b0; low_sw = 1'b0;
      repeat (LAT + 4) @(negedge clk);
      check("R5 short pulse pump", pump_a, 1'b0);
      // R5: short fault-shaped pulse does not raise the flag
      high_sw = 1'b1;
      repeat (DEB_N - 1) @(negedge clk);
      high_sw = 1'b0;
      repeat (LAT + 4) @(negedge clk);
      check("R5 short pulse fault", fault_a, 1'b0);

      // R4 band hold from both directions
      settle(1'b1, 1'b0);
      check("R4 rising into band stays off", pump_a, 1'b0);
      settle(1'b1, 1'b1);
      check("R3 both wet", pump_a, 1'b1);
      settle(1'b1, 1'b0);
      check("R4 draining in band stays on", pump_a, 1'b1);
      settle(1'b0, 1'b0);
      check("R2 both dry", pump_a, 1'b0);

      // Exhaustive sweep: every ordered pair of combos, from each pump state
      for (int pre = 0; pre < 2; pre++) begin
         for (int from = 0; from < 4; from++) begin
            for (int to = 0; to < 4; to++) begin
               do_reset();
               if (pre == 1) settle(1'b1, 1'b1);
               settle(from[0], from[1]);
               check("R1 R2 R3 R4 sweep from", pump_a, m_pump);
               settle(to[0], to[1]);
               check("R1 R2 R3 R4 sweep to", pump_a, m_pump);
               check("R7 fault model", fault_a, m_fault);
               check("R9 forms agree", pump_b, pump_a);
            end
         end
      end

      // R7 sticky across recovery, then R8 clears it
      do_reset();
      settle(1'b0, 1'b1);
      check("R3 forced on with failed lower", pump_a, 1'b1);
      check("R7 fault raised", fault_a, 1'b1);
      settle(1'b0, 1'b0);
      check("R7 fault sticky", fault_a, 1'b1);
      check("R2 off after recovery", pump_a, 1'b0);
      settle(1'b1, 1'b1);
      do_reset();
      @(negedge clk);
      check("R8 reset clears fault", fault_a, 1'b0);
      check("R8 reset stops pump", pump_a, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule